// File: doc/BRIEF.md
# Serial Key and Data Loader

This block collects two wide words from a host over a single serial data line: first a cipher key, then a plaintext block. The host drives one bit together with a send strobe. The block shows through a ready line whether it will take a bit on the next rising clock edge. Inside, a shift register and a bit counter assemble each word. When the last bit of a word arrives, a one-cycle word-received strobe tells a small controller that the word is complete. The controller then sets a load enable and a register select, and the word is written into either the key register or the data register.

The first completed word always goes to the key register and the second to the data register. After the second word a loaded flag rises, which tells the downstream cipher that it may start. From then on the block refuses further serial traffic until reset. The word width and the bit order are parameters. The default is a 128-bit word shifted most significant bit first. Reset is synchronous and active high.

Top module: `ser_loader_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rdy_o` is 1, and `rec_data_o`, `loaded_o`, `key_o` and `data_o` are all 0.
- R2: A bit is taken at a rising edge only when both `send_i` and `rdy_o` are high. Cycles with `send_i` low leave the word under assembly untouched, so gaps of any length between bits do not corrupt the word.
- R3: Bits are shifted in most significant first: the first bit taken ends in bit WORD_W-1 of the stored word and the last bit taken ends in bit 0.
- R4: `rec_data_o` is high for exactly one cycle, the cycle after the rising edge that takes the WORD_W-th bit of a word. `rdy_o` is low in that cycle.
- R5: The first completed word after reset appears on `key_o` in the cycle after the `rec_data_o` pulse. `data_o` is unchanged then, and neither register changes in any cycle that does not follow a `rec_data_o` pulse.
- R6: The second completed word appears on `data_o` in the cycle after its `rec_data_o` pulse. `loaded_o` rises in that same cycle and stays high until reset.
- R7: While `loaded_o` is high, `rdy_o` stays low, `rec_data_o` never pulses, and serial traffic leaves `key_o` and `data_o` unchanged.
- R8: A bit offered with `send_i` high while `rdy_o` is low, as in the `rec_data_o` cycle, is not taken and does not shift into the next word.
- R9: A reset in the middle of a word discards the partial word and the bit count. The next WORD_W bits then form a complete key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ser_bit_i | input | 1 | Serial data bit from the host |
| send_i | input | 1 | Host strobe: `ser_bit_i` holds a valid bit |
| rdy_o | output | 1 | Block will take a bit at the next edge |
| rec_data_o | output | 1 | One-cycle strobe: a full word has been assembled |
| key_o | output | WORD_W | Key register contents |
| data_o | output | WORD_W | Data register contents |
| loaded_o | output | 1 | Key and data both loaded |

## Verification
The bench targets these corner cases:
- A key whose top two bits and bottom bit are set. A design that reversed the bit order would show a different pattern on `key_o`.
- Random gaps in `send_i`. A design that shifted on idle cycles would garble the words.
- A bit driven with `send_i` high during the not-ready strobe cycle. A design that took that bit would push every later data bit one place and corrupt `data_o`.
- A reset in the middle of a word, followed by a full key. A counter that survived reset would end that key early.
- Traffic after both words are loaded. A design that kept listening would overwrite the key, or pulse the strobe, with the cipher's inputs already armed.

// File: rtl/ser_loader_pkg.sv
package ser_loader_pkg;

   // Which word the controller expects next.
   typedef enum logic [1:0] {
      ST_KEY  = 2'd0,
      ST_DATA = 2'd1,
      ST_FULL = 2'd2
   } load_state_t;

   // Register bank slot numbers; the key slot is filled first.
   localparam int unsigned SLOT_KEY  = 0;
   localparam int unsigned SLOT_DATA = 1;
   localparam int unsigned NUM_SLOTS = 2;

endpackage

// File: rtl/ser_shifter.sv
module ser_shifter #(
   parameter int unsigned WORD_W    = 128,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              take_i,
   input  logic              bit_i,
   output logic [WORD_W-1:0] word_o,
   output logic              done_o
);
   localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

   logic [WORD_W-1:0] shreg_q;
   logic [WORD_W-1:0] shreg_nxt;
   logic [CNT_W-1:0]  cnt_q;
   logic              done_q;
   logic              last_bit;

   generate
      if (MSB_FIRST) begin : g_msb
         always_comb shreg_nxt = {shreg_q[WORD_W-2:0], bit_i};
      end else begin : g_lsb
         always_comb shreg_nxt = {bit_i, shreg_q[WORD_W-1:1]};
      end
   endgenerate

   assign last_bit = take_i && (cnt_q == LAST_IDX);

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg_q <= '0;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last_bit;
         if (take_i) begin
            shreg_q <= shreg_nxt;
            cnt_q   <= last_bit ? '0 : cnt_q + 1'b1;
         end
      end
   end

   assign word_o = shreg_q;
   assign done_o = done_q;
endmodule

// File: rtl/ser_load_ctrl.sv
module ser_load_ctrl
   import ser_loader_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic word_done_i,
   output logic accept_o,
   output logic ld_en_o,
   output logic ld_sel_o,
   output logic full_o
);
   load_state_t st_q;
   load_state_t st_nxt;

   always_comb begin
      st_nxt = st_q;
      if (word_done_i) begin
         case (st_q)
            ST_KEY:  st_nxt = ST_DATA;
            ST_DATA: st_nxt = ST_FULL;
            default: st_nxt = st_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_KEY;
      else     st_q <= st_nxt;
   end

   // The word is consumed in the strobe cycle, so taking bits resumes right after.
   assign accept_o = (st_q != ST_FULL) && !word_done_i;
   assign ld_en_o  = word_done_i && (st_q != ST_FULL);
   assign ld_sel_o = (st_q == ST_DATA);
   assign full_o   = (st_q == ST_FULL);
endmodule

// File: rtl/ser_reg_bank.sv
module ser_reg_bank
   import ser_loader_pkg::*;
#(
   parameter int unsigned WORD_W = 128
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld_en_i,
   input  logic              ld_sel_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] key_o,
   output logic [WORD_W-1:0] data_o
);
   logic [WORD_W-1:0] slot_q [NUM_SLOTS];

   generate
      for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
         localparam logic SEL_VAL = (g == SLOT_DATA);
         always_ff @(posedge clk) begin
            if (rst)                                slot_q[g] <= '0;
            else if (ld_en_i && ld_sel_i == SEL_VAL) slot_q[g] <= word_i;
         end
      end
   endgenerate

   assign key_o  = slot_q[SLOT_KEY];
   assign data_o = slot_q[SLOT_DATA];
endmodule

// File: rtl/ser_loader_top.sv
module ser_loader_top #(
   parameter int unsigned WORD_W    = 128,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ser_bit_i,
   input  logic              send_i,
   output logic              rdy_o,
   output logic              rec_data_o,
   output logic [WORD_W-1:0] key_o,
   output logic [WORD_W-1:0] data_o,
   output logic              loaded_o
);
   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("ser_loader_top: WORD_W must be at least 2");
      end
   endgenerate

   logic              take;
   logic              word_done;
   logic              accept;
   logic              ld_en;
   logic              ld_sel;
   logic [WORD_W-1:0] word;

   assign take = send_i && accept;

   ser_shifter #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk    (clk),
      .rst    (rst),
      .take_i (take),
      .bit_i  (ser_bit_i),
      .word_o (word),
      .done_o (word_done)
   );

   ser_load_ctrl u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .word_done_i (word_done),
      .accept_o    (accept),
      .ld_en_o     (ld_en),
      .ld_sel_o    (ld_sel),
      .full_o      (loaded_o)
   );

   ser_reg_bank #(.WORD_W(WORD_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .ld_en_i  (ld_en),
      .ld_sel_i (ld_sel),
      .word_i   (word),
      .key_o    (key_o),
      .data_o   (data_o)
   );

   assign rdy_o      = accept;
   assign rec_data_o = word_done;
endmodule

// File: rtl/ser_loader_chk.sv
module ser_loader_chk #(
   parameter int unsigned WORD_W = 128
) (
   input logic              clk,
   input logic              rst,
   input logic              rdy_o,
   input logic              rec_data_o,
   input logic [WORD_W-1:0] key_o,
   input logic [WORD_W-1:0] data_o,
   input logic              loaded_o
);
   p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
      rec_data_o |=> !rec_data_o);

   p_busy_on_pulse_r4: assert property (@(posedge clk) disable iff (rst)
      rec_data_o |-> !rdy_o);

   p_regs_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !rec_data_o |=> ($stable(key_o) && $stable(data_o)));

   p_loaded_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      loaded_o |=> loaded_o);

   p_loaded_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      loaded_o |-> (!rdy_o && !rec_data_o));

   p_loaded_frozen_r7: assert property (@(posedge clk) disable iff (rst)
      loaded_o |=> ($stable(key_o) && $stable(data_o)));
endmodule

bind ser_loader_top ser_loader_chk #(.WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .rdy_o      (rdy_o),
   .rec_data_o (rec_data_o),
   .key_o      (key_o),
   .data_o     (data_o),
   .loaded_o   (loaded_o)
);

// File: tb/ser_loader_top_tb.sv
`timescale 1ns/1ps
module ser_loader_top_tb;
   localparam int unsigned W = 128;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         ser_bit = 1'b0;
   logic         send = 1'b0;
   logic         rdy;
   logic         rec_data;
   logic [W-1:0] key;
   logic [W-1:0] data;
   logic         loaded;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int unsigned seed_init;

   always #2.5 clk = ~clk;

   ser_loader_top #(.WORD_W(W)) u_dut (
      .clk(clk), .rst(rst), .ser_bit_i(ser_bit), .send_i(send),
      .rdy_o(rdy), .rec_data_o(rec_data), .key_o(key), .data_o(data),
      .loaded_o(loaded)
   );

   function automatic logic [W-1:0] rand_word();
      logic [W-1:0] w;
      for (int k = 0; k < W / 32; k++) w[k*32 +: 32] = $urandom;
      return w;
   endfunction

   task automatic chk(input bit ok, input string tag,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; send = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // Offers bits MSB first with random idle gaps; the last one is taken at the next edge.
   task automatic send_word(input logic [W-1:0] v, input int gap_pct);
      int i = W - 1;
      while (i >= 0) begin
         @(negedge clk);
         if (($urandom % 100) < gap_pct) begin
            send = 1'b0; ser_bit = $urandom;
         end else begin
            send = 1'b1; ser_bit = v[i];
            if (rdy) i--;
         end
      end
   endtask

   // Strobe cycle with a junk bit offered (R8), then the register check.
   task automatic finish_word(input bit is_key, input logic [W-1:0] v,
                              input logic [W-1:0] exp_other, input string tag);
      @(negedge clk);
      chk(rec_data === 1'b1 && rdy === 1'b0, "R4 strobe high, ready low",
          {rec_data, rdy}, 2'b10);
      send = 1'b1; ser_bit = ~v[W-1];
      @(negedge clk);
      send = 1'b0;
      chk(rec_data === 1'b0, "R4 strobe lasts one cycle", rec_data, 0);
      if (is_key) begin
         chk(key === v, {tag, " key_o"}, key, v);
         chk(data === exp_other, "R5 data_o unchanged by key load", data, exp_other);
         chk(loaded === 1'b0, "R6 loaded_o low after key only", loaded, 0);
      end else begin
         chk(data === v, {tag, " data_o"}, data, v);
         chk(key === exp_other, "R5 key_o unchanged by data load", key, exp_other);
         chk(loaded === 1'b1, "R6 loaded_o high after data", loaded, 1);
      end
   endtask

   task automatic session(input logic [W-1:0] k, input logic [W-1:0] d,
                          input int gap_pct);
      send_word(k, gap_pct);
      finish_word(1'b1, k, '0, "R2 R3 R5 R9");
      send_word(d, gap_pct);
      finish_word(1'b0, d, k, "R2 R6 R8");
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] k0;
      logic [W-1:0] d0;
      int bad;
      seed_init = $urandom(32'h5EED_0C1A);

      // R1: values while reset is held and just after release
      @(negedge clk);
      chk(rdy === 1'b1 && rec_data === 1'b0 && loaded === 1'b0,
          "R1 control outputs in reset", {rdy, rec_data, loaded}, 3'b100);
      do_reset();
      @(negedge clk);
      chk(key === '0 && data === '0, "R1 registers cleared", key | data, '0);
      chk(rdy === 1'b1, "R1 ready after reset", rdy, 1);

      // Directed: asymmetric key exposes bit order (R3)
      k0 = {2'b11, {(W-3){1'b0}}, 1'b1};
      d0 = rand_word();
      session(k0, d0, 0);

      // R7: traffic after loading is refused
      bad = 0;
      for (int c = 0; c < W + 10; c++) begin
         @(negedge clk);
         send = 1'b1; ser_bit = $urandom;
         if (rdy !== 1'b0 || rec_data !== 1'b0) bad++;
      end
      @(negedge clk);
      send = 1'b0;
      chk(bad == 0, "R7 ready low, no strobe when loaded", bad, 0);
      chk(key === k0 && data === d0, "R7 registers frozen when loaded",
          key ^ k0 | data ^ d0, '0);
      chk(loaded === 1'b1, "R7 loaded_o stays high", loaded, 1);

      // R9: reset in the middle of a word
      do_reset();
      for (int c = 0; c < 50; c++) begin
         @(negedge clk);
         send = 1'b1; ser_bit = $urandom;
      end
      do_reset();
      @(negedge clk);
      chk(loaded === 1'b0 && key === '0, "R9 R1 cleared after mid-word reset",
          key, '0);
      session(rand_word(), rand_word(), 30);

      // Random sessions with varied gap density (R2)
      for (int s = 0; s < 4; s++) begin
         do_reset();
         session(rand_word(), (s == 0) ? '1 : rand_word(), 10 + 20 * s);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule